// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus side of a 4096-byte serial memory that answers on a two-wire, open-drain bus. The clock and data lines arrive as plain logic levels. The block resamples them on its own system clock and picks out start conditions, stop conditions and clock edges. It then decodes a device byte made of a fixed type code and three strap pins, followed by a read/write bit. It pulls the data line low for acknowledges and for zero bits of read data. It never drives the line high.

A write transaction carries two word-address bytes and then one or more data bytes. The data bytes are staged in a buffer the size of one page. They reach the array only when a stop arrives. After that stop, the block stays deaf for a programmable number of system clocks. A master can poll with device bytes until one is acknowledged.

Reads come in three forms:
- A current-address read uses an internal counter.
- A random read is a write of the two address bytes, then a repeated start.
- A sequential read continues for as long as the master acknowledges.

A stop placed right after the address bytes only loads the counter. Word address FFFFh selects a one-byte protect register in place of the array.

Top module: `twsm_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) arms the receiver for a device byte from any non-busy state. A stop (SDA rising while SCL is high) ends the transaction. SDA changes while SCL is low are taken as data, and the block changes its own pull only while SCL is low.
- R2: The device byte is type code 1010 in bits 7..4, strap pins in bits 3..1 and R/W in bit 0 (1 = read). On a mismatch there is no acknowledge on the ninth clock, and further bytes are ignored until the next start.
- R3: A write takes address byte 1 (bits 11..8 of the address in its low nibble) and then address byte 0 (bits 7..0), and acknowledges each. The upper nibble of byte 1 is ignored, except that both bytes all ones select the register.
- R4: Each array data byte is acknowledged and staged at the counter. Only the low 5 counter bits advance, wrapping inside the 32-byte page. A stop writes the staged bytes into the array.
- R5: A start that arrives while data is staged discards that data, and no write cycle follows.
- R6: For WC_CYCLES system clocks after a committing stop, the block pulls SDA for nothing, not even its own device byte. After that it responds again.
- R7: The counter holds the last written or read address plus one. Reads advance it over the whole 12-bit space, wrapping FFFh to 000h.
- R8: During a read, a master acknowledge on the ninth clock brings the next byte. A no-acknowledge leaves SDA released until the next start or stop.
- R9: A stop right after the two address bytes loads the counter and starts no write cycle, so the block answers immediately.
- R10: At address FFFFh only the first data byte is acknowledged; later bytes get no acknowledge and are dropped. The stored value has bits 6, 5 and 0 cleared. A read there returns the register, sets the counter to 0000h and sends one byte only, even if the master acknowledges.
- R11: After reset SDA is released and the register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level, asynchronous |
| sda_in | input | 1 | Bus data level, asynchronous |
| dev_sel | input | 3 | Strap pins compared with device byte bits 3..1 |
| sda_pull | output | 1 | 1 = pull the data line low |

## Verification
A wrong internal state shows at the ports within one byte.

| Internal fault | What the port shows |
|---|---|
| Stray bit counter or role | Acknowledge lands on the wrong clock, or a matching device byte gets no acknowledge |
| Wrong page wrap or counter advance | Wrong byte at a later random, current or sequential read |
| Busy window too long | A poll that should be acknowledged is refused |
| Busy window too short | A poll inside the window is acknowledged at once |
| Leaked staging buffer | The discard case writes the array |

Register masking and one-byte termination are checked through the data value and through the released line after the single byte.

// File: rtl/twsm_pkg.sv
package twsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT, ST_BUSY
  } bus_state_t;

  typedef enum logic [1:0] {RL_DEV, RL_AHI, RL_ALO, RL_DATA} rx_role_t;

  localparam logic [3:0]  TYPE_CODE     = 4'b1010;
  localparam logic [7:0]  REG_KEEP_MASK = 8'b1001_1110;
  localparam logic [15:0] REG_ADDR      = 16'hFFFF;

  // read advance: whole array space, wraps to zero
  function automatic logic [15:0] rd_next(logic [15:0] a, int aw);
    logic [15:0] m;
    m = 16'((32'd1 << aw) - 32'd1);
    return (a + 16'd1) & m;
  endfunction

  // write advance: only the in-page bits move
  function automatic logic [15:0] wr_next(logic [15:0] a, int pw);
    logic [15:0] m;
    m = 16'((32'd1 << pw) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  function automatic logic dev_hit(logic [7:0] b, logic [2:0] sel);
    return b[7:1] == {TYPE_CODE, sel};
  endfunction

endpackage

// File: rtl/twsm_edge.sv
module twsm_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_N:0] scl_q, sda_q;
  logic scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC_N-1:0], scl_in};
      sda_q <= {sda_q[SYNC_N-1:0], sda_in};
    end
  end

  assign scl_now  = scl_q[SYNC_N-1];
  assign scl_old  = scl_q[SYNC_N];
  assign sda_now  = sda_q[SYNC_N-1];
  assign sda_old  = sda_q[SYNC_N];
  assign sda_lvl  = sda_now;
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_ev = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_ev  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/twsm_store.sv
module twsm_store
  import twsm_pkg::*;
#(
  parameter int MEM_AW  = 12,
  parameter int PAGE_AW = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      buf_clear,
  input  logic                      buf_wr,
  input  logic                      buf_to_reg,
  input  logic [PAGE_AW-1:0]        buf_idx,
  input  logic [7:0]                buf_data,
  input  logic                      commit,
  input  logic [MEM_AW-PAGE_AW-1:0] commit_page,
  input  logic [MEM_AW-1:0]         rd_addr,
  output logic [7:0]                rd_data,
  output logic [7:0]                reg_q,
  output logic                      pend
);
  localparam int PAGE_N = 1 << PAGE_AW;
  localparam int DEPTH  = 1 << MEM_AW;

  logic [7:0]        mem    [DEPTH];
  logic [7:0]        pg_buf [PAGE_N];
  logic [PAGE_N-1:0] pg_v;
  logic [7:0]        reg_hold;
  logic              reg_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_v  <= '0;
      reg_v <= 1'b0;
      reg_q <= 8'h00;
    end else if (buf_clear || commit) begin
      if (commit && reg_v) reg_q <= reg_hold & REG_KEEP_MASK;
      pg_v  <= '0;
      reg_v <= 1'b0;
    end else if (buf_wr) begin
      if (buf_to_reg) reg_v <= 1'b1;
      else            pg_v[buf_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_wr && buf_to_reg)  reg_hold <= buf_data;
    if (buf_wr && !buf_to_reg) pg_buf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_N; i++) begin
        if (pg_v[i]) mem[{commit_page, PAGE_AW'(i)}] <= pg_buf[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign pend    = (|pg_v) | reg_v;

  AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend); // R4
endmodule

// File: rtl/twsm_slave.sv
module twsm_slave
  import twsm_pkg::*;
#(
  parameter int MEM_AW    = 12,
  parameter int PAGE_AW   = 5,
  parameter int WC_CYCLES = 200,
  parameter int SYNC_N    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] dev_sel,
  output logic       sda_pull
);
  localparam int WC_W = $clog2(WC_CYCLES + 1);

  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  twsm_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bus_state_t st;
  rx_role_t   role;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg, txbyte, ahi;
  logic [15:0]     waddr;
  logic            rd_mode, mack, last, reg_taken;
  logic [WC_W-1:0] wc_cnt;

  logic busy, is_reg, byte_in, buf_clear, buf_wr, commit, pend;
  logic [7:0] rd_data, reg_q, tx_val;
  logic [15:0] tx_adv;

  assign busy      = (st == ST_BUSY);
  assign is_reg    = (waddr == REG_ADDR);
  assign byte_in   = (st == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign buf_wr    = byte_in && (role == RL_DATA) && (!is_reg || !reg_taken);
  assign buf_clear = (start_ev && !busy) || (byte_in && role == RL_ALO);
  assign commit    = stop_ev && !busy && pend;
  assign tx_val    = is_reg ? reg_q : rd_data;
  assign tx_adv    = is_reg ? 16'h0000 : rd_next(waddr, MEM_AW);

  twsm_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_wr(buf_wr),
    .buf_to_reg(is_reg), .buf_idx(waddr[PAGE_AW-1:0]), .buf_data(shreg),
    .commit(commit), .commit_page(waddr[MEM_AW-1:PAGE_AW]),
    .rd_addr(waddr[MEM_AW-1:0]), .rd_data(rd_data), .reg_q(reg_q), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; role <= RL_DEV; bitcnt <= '0; shreg <= '0;
      txbyte <= '0; ahi <= '0; waddr <= '0; rd_mode <= 1'b0;
      mack <= 1'b0; last <= 1'b0; reg_taken <= 1'b0;
      wc_cnt <= '0; sda_pull <= 1'b0;
    end else if (busy) begin
      if (wc_cnt <= WC_W'(1)) st <= ST_IDLE;
      else                    wc_cnt <= wc_cnt - WC_W'(1);
    end else if (start_ev) begin
      st <= ST_RX; role <= RL_DEV; bitcnt <= '0; sda_pull <= 1'b0;
    end else if (stop_ev) begin
      sda_pull <= 1'b0;
      if (pend) begin
        st <= ST_BUSY; wc_cnt <= WC_W'(WC_CYCLES);
      end else begin
        st <= ST_IDLE;
      end
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_in) begin
            case (role)
              RL_DEV: begin
                if (dev_hit(shreg, dev_sel)) begin
                  rd_mode <= shreg[0]; sda_pull <= 1'b1; st <= ST_RX_ACK;
                  role <= RL_AHI;
                end else begin
                  st <= ST_WAIT;
                end
              end
              RL_AHI: begin
                ahi <= shreg; sda_pull <= 1'b1; st <= ST_RX_ACK; role <= RL_ALO;
              end
              RL_ALO: begin
                waddr <= {ahi, shreg}; reg_taken <= 1'b0;
                sda_pull <= 1'b1; st <= ST_RX_ACK; role <= RL_DATA;
              end
              default: begin
                if (is_reg) begin
                  if (!reg_taken) begin
                    reg_taken <= 1'b1; sda_pull <= 1'b1; st <= ST_RX_ACK;
                  end else begin
                    st <= ST_WAIT;
                  end
                end else begin
                  waddr <= wr_next(waddr, PAGE_AW);
                  sda_pull <= 1'b1; st <= ST_RX_ACK;
                end
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              txbyte <= tx_val; sda_pull <= ~tx_val[7];
              waddr <= tx_adv; last <= is_reg; st <= ST_TX;
            end else begin
              sda_pull <= 1'b0; st <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_pull <= 1'b0; bitcnt <= '0; st <= ST_TX_ACK;
            end else begin
              txbyte <= txbyte << 1; sda_pull <= ~txbyte[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack <= ~sda_lvl;
          if (scl_fall) begin
            if (mack && !last) begin
              txbyte <= tx_val; sda_pull <= ~tx_val[7];
              waddr <= tx_adv; last <= is_reg; st <= ST_TX;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull); // R6
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev)); // R6
  AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall)); // R1
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !busy) |=> (st == ST_RX && bitcnt == 4'd0 && !sda_pull)); // R1
  AST_REG_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX_ACK && last && scl_fall && !start_ev && !stop_ev)
      |=> (st == ST_WAIT)); // R10
endmodule

// File: tb/tb_twsm_slave.sv
module tb_twsm_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam int H     = 16;
  localparam int WC    = 60;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] DW  = 8'hAA;
  localparam logic [7:0] DR  = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  wire  sda_bus = sda_m & ~sda_pull;
  int nchk = 0, nbad = 0;
  logic [7:0] wbuf [8];

  always #(CLK_P/2) clk = ~clk;

  twsm_slave #(.WC_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .dev_sel(SEL), .sda_pull(sda_pull)
  );

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(H/2);
    ack = ~sda_bus; tick(H/2); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2); scl_m = 1'b0;
    end
    tick(2); sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    tick(2); sda_m = 1'b1;
  endtask

  task automatic mem_write(input logic [15:0] a, input int n, output logic all_ack);
    logic k;
    all_ack = 1'b1;
    do_start;
    send_byte(DW, k); all_ack &= k;
    send_byte(a[15:8], k); all_ack &= k;
    send_byte(a[7:0], k); all_ack &= k;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], k); all_ack &= k; end
    do_stop;
  endtask

  task automatic rand_read(input logic [15:0] a, output logic [7:0] d);
    logic k;
    do_start; send_byte(DW, k); send_byte(a[15:8], k); send_byte(a[7:0], k);
    do_start; send_byte(DR, k); recv_byte(1'b0, d); do_stop;
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic k;
    do_start; send_byte(DR, k); recv_byte(1'b0, d); do_stop;
  endtask

  task automatic wait_wc; tick(WC + 10); endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R11 pull after reset", {7'd0, sda_pull}, 8'h00);
    rand_read(16'hFFFF, d);
    chk("R11 register reset value", d, 8'h00);
  endtask

  task automatic t_mismatch;
    logic k;
    do_start; send_byte(8'hA0, k); chk("R2 wrong strap nack", {7'd0, k}, 8'h00);
    send_byte(DW, k); chk("R2 ignored until start", {7'd0, k}, 8'h00);
    do_stop;
    do_start; send_byte(8'hBA, k); chk("R2 wrong type nack", {7'd0, k}, 8'h00);
    do_stop;
  endtask

  task automatic t_write_busy;
    logic k; logic [7:0] d;
    wbuf[0] = 8'h5A; mem_write(16'h0123, 1, k);
    chk("R1 R3 write acks", {7'd0, k}, 8'h01);
    do_start; send_byte(DW, k); do_stop;
    chk("R6 silent in write cycle", {7'd0, k}, 8'h00);
    wait_wc;
    do_start; send_byte(DW, k); do_stop;
    chk("R6 answers after cycle", {7'd0, k}, 8'h01);
    rand_read(16'h0123, d); chk("R4 byte written", d, 8'h5A);
    wbuf[0] = 8'h3C; mem_write(16'hF124, 1, k); wait_wc;
    rand_read(16'h0124, d); chk("R3 upper nibble ignored", d, 8'h3C);
  endtask

  task automatic t_page;
    logic k; logic [7:0] d;
    wbuf[0] = 8'h77; mem_write(16'h01E1, 1, k); wait_wc;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    mem_write(16'h01FE, 3, k); wait_wc;
    cur_read(d); chk("R4 R7 counter after page wrap", d, 8'h77);
    rand_read(16'h01FE, d); chk("R4 page byte 30", d, 8'hA1);
    rand_read(16'h01FF, d); chk("R4 page byte 31", d, 8'hA2);
    rand_read(16'h01E0, d); chk("R4 page wrap to byte 0", d, 8'hA3);
  endtask

  task automatic t_discard;
    logic k; logic [7:0] d;
    wbuf[0] = 8'h11; mem_write(16'h0300, 1, k); wait_wc;
    do_start; send_byte(DW, k); send_byte(8'h03, k); send_byte(8'h00, k);
    send_byte(8'h99, k);
    do_start; send_byte(DW, k);
    chk("R5 no write cycle after restart", {7'd0, k}, 8'h01);
    do_stop;
    do_start; send_byte(DW, k); do_stop;
    chk("R5 still no write cycle", {7'd0, k}, 8'h01);
    rand_read(16'h0300, d); chk("R5 staged data dropped", d, 8'h11);
  endtask

  task automatic t_setaddr;
    logic k; logic [7:0] d;
    do_start; send_byte(DW, k); send_byte(8'h01, k); send_byte(8'h23, k); do_stop;
    do_start; send_byte(DR, k);
    chk("R9 immediate answer", {7'd0, k}, 8'h01);
    recv_byte(1'b0, d); do_stop;
    chk("R9 counter loaded", d, 8'h5A);
  endtask

  task automatic t_seq;
    logic k; logic [7:0] d;
    wbuf[0] = 8'hE1; mem_write(16'h0FFF, 1, k); wait_wc;
    wbuf[0] = 8'hE2; mem_write(16'h0000, 1, k); wait_wc;
    do_start; send_byte(DW, k); send_byte(8'h0F, k); send_byte(8'hFF, k);
    do_start; send_byte(DR, k);
    recv_byte(1'b1, d); chk("R7 read top of array", d, 8'hE1);
    recv_byte(1'b0, d); chk("R7 R8 read wraps to zero", d, 8'hE2);
    recv_byte(1'b0, d); chk("R8 released after nack", d, 8'hFF);
    do_stop;
  endtask

  task automatic t_reg;
    logic k; logic [7:0] d;
    do_start; send_byte(DW, k); send_byte(8'hFF, k); send_byte(8'hFF, k);
    send_byte(8'hFF, k); chk("R10 first register byte ack", {7'd0, k}, 8'h01);
    send_byte(8'h12, k); chk("R10 second register byte nack", {7'd0, k}, 8'h00);
    do_stop; wait_wc;
    do_start; send_byte(DW, k); send_byte(8'hFF, k); send_byte(8'hFF, k);
    do_start; send_byte(DR, k);
    recv_byte(1'b1, d); chk("R10 masked register value", d, 8'h9E);
    recv_byte(1'b0, d); chk("R10 one byte only", d, 8'hFF);
    do_stop;
    cur_read(d); chk("R10 counter zero after register", d, 8'hE2);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset;
    t_mismatch;
    t_write_busy;
    t_page;
    t_discard;
    t_setaddr;
    t_seq;
    t_reg;
    finish_run;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    finish_run;
  end
endmodule